// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag and Pin Logic

This block keeps the three interrupt flags of a real-time clock: the periodic update flag, the countdown timer flag and the alarm flag. Each source delivers a one-cycle event pulse that sets its flag. A flag stays set until software clears it, so the cause of an interrupt is never lost, and every flag can be polled whatever the enable settings are.

Each flag has its own enable bit. The block combines the three enabled flags into one request for a shared active-low open-drain interrupt pin. The pin is modelled as a drive-enable: 1 means the pin is pulled low and 0 means the pin is released to high impedance. Clearing an enable releases the pin without changing the flag behind it. Software uses a plain parallel port to read the flags and enables, and write strobes with data to change them.

Top module: `rtc_irq_flags`

## Requirements
- R1: After a synchronous active-low reset, all flags, all enables and the pin drive-enable read 0.
- R2: An event pulse on a source sets that source's flag at the next clock edge. Bit 0 is update, bit 1 is timer and bit 2 is alarm, in every vector port.
- R3: A set flag stays set in every cycle in which software does not clear it. Hardware never clears a flag.
- R4: A flag write clears each flag whose data bit is 0. A data bit of 1 leaves its flag unchanged.
- R5: When an event pulse and a clearing flag write for the same source arrive in the same cycle, the flag is set after the edge.
- R6: An enable write loads all three enable bits from the write data at the next clock edge. Otherwise the enables hold their values.
- R7: The pin drive-enable is a register that equals the OR over sources of (flag AND enable). It changes at the same edge as the flag or enable change that causes it.
- R8: Writing 0 to the enable of a set flag releases the pin, provided no other enabled flag is set, and the flag stays 1.
- R9: While all enables are 0, the pin drive-enable stays 0, and events still set their flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 3 | One-cycle event pulses {alarm, timer, update} |
| flag_wr_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 3 | Flag write data. 0 clears, 1 keeps |
| en_wr_i | input | 1 | Enable write strobe |
| en_wdata_i | input | 3 | Enable write data |
| flag_o | output | 3 | Flag read value |
| en_o | output | 3 | Enable read value |
| irq_drive_o | output | 1 | 1 pulls the shared pin low, 0 releases it |

## Verification
A source event and a software clear of the same flag can fall in the same cycle, and that is the race that matters most. The bench provokes it with directed cycles in which the pulse and the clearing write hit the same bit together. It also provokes it through random stimulus in which events and flag writes often overlap. A reference model in the bench gives the event priority over the clear, and the flag read value and the pin drive are compared with the model after every edge.

// File: rtl/rtc_irq_pkg.sv
// Shared constants for the real-time clock interrupt flag logic.
// Assumes that each source position is the same in every vector port.
package rtc_irq_pkg;
    localparam int unsigned NSRC    = 3;
    localparam int unsigned SRC_UPD = 0;
    localparam int unsigned SRC_TMR = 1;
    localparam int unsigned SRC_ALM = 2;
endpackage

// File: rtl/irq_flag_cell.sv
// One interrupt source: a sticky flag and its enable bit.
// Assumptions: evt_i is a single-cycle pulse. A clearing write loses to a
// simultaneous event. next-state values are exported so that the pin
// register can follow without a cycle of lag.
module irq_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic flag_wr_i,
    input  logic flag_wbit_i,
    input  logic en_wr_i,
    input  logic en_wbit_i,
    output logic flag_q_o,
    output logic en_q_o,
    output logic flag_d_o,
    output logic en_d_o
);
    logic clr;

    // Next state: a clear needs a write with a 0 bit, and an event overrides it.
    always_comb begin
        clr      = flag_wr_i && !flag_wbit_i;
        flag_d_o = evt_i || (flag_q_o && !clr);
        en_d_o   = en_wr_i ? en_wbit_i : en_q_o;
    end

    // State registers for the flag and its enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q_o <= 1'b0;
            en_q_o   <= 1'b0;
        end else begin
            flag_q_o <= flag_d_o;
            en_q_o   <= en_d_o;
        end
    end

    // R2 and R5: an event always leaves the flag set.
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> flag_q_o);
    // R3: without a clearing write, a set flag holds.
    a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q_o && !(flag_wr_i && !flag_wbit_i)) |=> flag_q_o);
    // R4: a clearing write with no event clears the flag.
    a_r4_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr_i && !flag_wbit_i && !evt_i) |=> !flag_q_o);
    // R6: an enable holds without a write.
    a_r6_en_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !en_wr_i |=> $stable(en_q_o));
endmodule

// File: rtl/irq_pin_drive.sv
// Merges the enabled flags of all sources into one registered drive-enable
// for the shared open-drain pin. The register takes the next-state values,
// so the output is glitch-free and has no extra cycle of latency.
module irq_pin_drive #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flag_d_i,
    input  logic [N-1:0] en_d_i,
    output logic         drive_o
);
    logic req;

    // Any enabled, set flag requests a low drive.
    always_comb req = |(flag_d_i & en_d_i);

    // Drive register, released while in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) drive_o <= 1'b0;
        else        drive_o <= req;
    end

    // R9: with every enable off, the pin is never driven.
    a_r9_no_drive_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (en_d_i == '0) |=> !drive_o);
endmodule

// File: rtl/rtc_irq_flags.sv
// Top level: three sticky interrupt flags (update, timer, alarm) with their
// enables, and a shared active-low open-drain interrupt drive-enable.
// Assumes one-cycle event pulses, and parallel write strobes with data.
module rtc_irq_flags
    import rtc_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    input  logic            flag_wr_i,
    input  logic [NSRC-1:0] flag_wdata_i,
    input  logic            en_wr_i,
    input  logic [NSRC-1:0] en_wdata_i,
    output logic [NSRC-1:0] flag_o,
    output logic [NSRC-1:0] en_o,
    output logic            irq_drive_o
);
    logic [NSRC-1:0] flag_d;
    logic [NSRC-1:0] en_d;

    // One flag cell for each interrupt source.
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        irq_flag_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .evt_i      (evt_i[s]),
            .flag_wr_i  (flag_wr_i),
            .flag_wbit_i(flag_wdata_i[s]),
            .en_wr_i    (en_wr_i),
            .en_wbit_i  (en_wdata_i[s]),
            .flag_q_o   (flag_o[s]),
            .en_q_o     (en_o[s]),
            .flag_d_o   (flag_d[s]),
            .en_d_o     (en_d[s])
        );
    end

    // Shared pin drive.
    irq_pin_drive #(.N(NSRC)) u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .flag_d_i(flag_d),
        .en_d_i  (en_d),
        .drive_o (irq_drive_o)
    );

    // R7: the pin register agrees with the flag and enable registers.
    a_r7_pin_matches: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_drive_o == |(flag_o & en_o)));
    // R8: dropping every enable releases the pin and leaves the flags alone.
    a_r8_release_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr_i && en_wdata_i == '0 && !flag_wr_i) |=> (!irq_drive_o && (flag_o == $past(flag_o | evt_i))));
endmodule

// File: tb/rtc_irq_flags_tb.sv
// Self-checking bench: directed corner cases plus seeded random stimulus.
module rtc_irq_flags_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] evt = '0;
    logic       fwr = 1'b0;
    logic [2:0] fdat = '0;
    logic       ewr = 1'b0;
    logic [2:0] edat = '0;
    logic [2:0] flag_o;
    logic [2:0] en_o;
    logic       drv_o;

    int total = 0;
    int bad = 0;
    logic [2:0] mflag = '0;
    logic [2:0] men = '0;

    always #10 clk = ~clk;

    rtc_irq_flags dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .flag_wr_i(fwr),
        .flag_wdata_i(fdat), .en_wr_i(ewr), .en_wdata_i(edat),
        .flag_o(flag_o), .en_o(en_o), .irq_drive_o(drv_o)
    );

    // Reference flag update, taken from the requirements.
    function automatic logic [2:0] next_flag(logic [2:0] f, logic [2:0] e, logic w, logic [2:0] d);
        return e | (f & ~(w ? ~d : 3'b000));
    endfunction

    function automatic logic [2:0] next_en(logic [2:0] c, logic w, logic [2:0] d);
        return w ? d : c;
    endfunction

    task automatic chk(string req, logic [2:0] got, logic [2:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // One cycle: drive at the falling edge, then check just after the rising edge.
    task automatic step(logic [2:0] e, logic w, logic [2:0] d, logic ew, logic [2:0] ed, string req);
        @(negedge clk);
        evt = e; fwr = w; fdat = d; ewr = ew; edat = ed;
        mflag = next_flag(mflag, e, w, d);
        men = next_en(men, ew, ed);
        @(posedge clk); #1;
        evt = '0; fwr = 1'b0; ewr = 1'b0;
        chk({req, " flags"}, flag_o, mflag);
        chk({req, " enables"}, en_o, men);
        chk({req, " drive"}, {2'b00, drv_o}, {2'b00, |(mflag & men)});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state.
        chk("R1 flags", flag_o, 3'b000);
        chk("R1 enables", en_o, 3'b000);
        chk("R1 drive", {2'b00, drv_o}, 3'b000);
        @(negedge clk); rst_n = 1'b1;
        // R9: events with all enables off set the flags, and the pin stays released.
        step(3'b111, 1'b0, 3'b000, 1'b0, 3'b000, "R9");
        step(3'b000, 1'b0, 3'b000, 1'b0, 3'b000, "R3");
        // R4: writing 1 keeps, writing 0 clears (bit 1, the timer).
        step(3'b000, 1'b1, 3'b101, 1'b0, 3'b000, "R4");
        // R6 and R7: enable the alarm, and the pin drives at once.
        step(3'b000, 1'b0, 3'b000, 1'b1, 3'b100, "R6");
        // R8: disabling releases the pin, and the flags stay.
        step(3'b000, 1'b0, 3'b000, 1'b1, 3'b000, "R8");
        // R5: an event together with a clear on the update bit.
        step(3'b001, 1'b1, 3'b000, 1'b1, 3'b001, "R5");
        step(3'b000, 1'b1, 3'b000, 1'b0, 3'b000, "R7");
        // R2: each source alone, with all enables on.
        step(3'b000, 1'b0, 3'b000, 1'b1, 3'b111, "R6");
        for (int s = 0; s < 3; s++) begin
            step(3'b001 << s, 1'b0, 3'b000, 1'b0, 3'b000, "R2");
            step(3'b000, 1'b1, 3'b000, 1'b0, 3'b000, "R4");
        end
        // Random mix of R2, R3, R4, R5, R6 and R7 against the model.
        for (int i = 0; i < 400; i++) begin
            step(3'($urandom), ($urandom % 3) == 0, 3'($urandom),
                 ($urandom % 4) == 0, 3'($urandom), "R7 random");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule